// File: doc/BRIEF.md
# LPC Single-Byte Write Target

This block sits on the peripheral side of a Low Pin Count bus and accepts single-byte write cycles from the host. On every rising clock edge it samples the active-low frame strobe and the 4-bit shared address/data lines. It recognises a start nibble, checks a cycle-type nibble, and collects a 32-bit address and an 8-bit data byte. After the host's turnaround clock it takes the lines, acknowledges with a sync nibble and then returns the lines to the host.

Address decoding uses a band of upper address bits that must all be 1. A write that fails the type check or the address check gets no response: the block never drives the lines and issues no write. For an accepted cycle the block raises a one-clock write strobe during the sync clock. The strobe comes with the address, the data byte and a flag that tells memory space from register space. The flag is taken from one address bit. The core that receives the write decides what the write does.

A full accepted cycle lasts 17 clocks. The host drives clocks 1 to 13 and the target drives clocks 14 to 16. In clock 17 the lines float. If the frame strobe falls in the middle of a cycle, the block drops that cycle and starts decoding again.

Top module: `lpc_write_target`

## Requirements
- R1: A cycle begins only when, at a rising edge, `frameN` is 0 and `ladIn` is 4'b0000 (this is clock 1). A low frame strobe with any other nibble leaves the block idle, and the cycle that follows draws no response.
- R2: The nibble in clock 2 is the cycle type. It is accepted only when bits 3:2 are 2'b01 and bit 1 is 1 (write); bit 0 is ignored. Any other type value makes the block ignore the rest of the cycle.
- R3: Clocks 3 to 10 carry the 32-bit address, most significant nibble first. It appears on `wrAddr`.
- R4: The cycle is accepted only if address bits 31 down to 23 are all 1. Otherwise the block stays silent: `ladOe` stays 0 and there is no strobe.
- R5: `wrIsMem` equals address bit 22 (1 = memory access, 0 = register access).
- R6: Clocks 11 and 12 carry the data byte, least significant nibble first. It appears on `wrData`.
- R7: For an accepted cycle, `ladOe` is 1 in clocks 14, 15 and 16 only. `ladOut` is 4'b1111 in clock 14, 4'b0000 (sync) in clock 15 and 4'b1111 in clock 16. In clock 17, and in every clock outside an accepted cycle, `ladOe` is 0.
- R8: `wrStrobe` is a single-clock pulse in clock 15 of an accepted cycle. `wrAddr`, `wrData` and `wrIsMem` are valid while it is high.
- R9: If `frameN` is 0 at any rising edge after clock 1, the current cycle is abandoned without a write, and `ladOe` is 0 in the following clock. If the nibble sampled with it is 4'b0000, that edge counts as clock 1 of a new cycle.
- R10: While `rstN` is 0 the block is idle: `ladOe` and `wrStrobe` are 0 at once, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising-edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| frameN | input | 1 | Frame strobe from the host, active low |
| ladIn | input | 4 | Value sampled from the shared address/data lines |
| ladOut | output | 4 | Value the target drives onto the shared lines |
| ladOe | output | 1 | Tri-state enable for `ladOut` |
| wrStrobe | output | 1 | One-clock write pulse for an accepted cycle |
| wrAddr | output | 32 | Decoded address |
| wrData | output | 8 | Received data byte |
| wrIsMem | output | 1 | 1 = memory space, 0 = register space |

## Verification
The bench builds the block with its default parameters: eight address nibbles, two data nibbles, a filter band on bits 31 to 23 and the space select on bit 22. With these values the full 17-clock sequence is exercised, both sides of every filter bit edge can be reached with ordinary addresses, and both memory and register writes can be sent. A bus model merges the host's drive with the target's tri-state output. This lets the bench check every clock of each cycle, including restarts triggered by the frame strobe and a reset during the target-driven phase.

// File: rtl/lpcw_pkg.sv
package lpcw_pkg;

  // Phase of the bus cycle the target believes the current clock belongs to.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TYPE,
    ST_ADDR,
    ST_DATA,
    ST_HTAR,
    ST_TTAR0,
    ST_SYNC,
    ST_TTAR1
  } busPhase_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clear;
    logic shiftAddr;
    logic loadData;
  } dpCtl_t;

  localparam logic [3:0] NIB_START = 4'b0000;
  localparam logic [3:0] NIB_TURN  = 4'b1111;
  localparam logic [3:0] NIB_SYNC  = 4'b0000;

  // Single-byte write type: bits 3:2 = 01, bit 1 = 1, bit 0 ignored.
  function automatic logic isWriteType(input logic [3:0] nib);
    return (nib[3:2] == 2'b01) && nib[1];
  endfunction

endpackage

// File: rtl/lpcw_ctrl.sv
module lpcw_ctrl
  import lpcw_pkg::*;
#(
  parameter int ADDR_NIBBLES = 8,
  parameter int DATA_NIBBLES = 2,
  parameter int CW           = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameN,
  input  logic [3:0]    ladIn,
  input  logic          addrOk,
  output dpCtl_t        dpCtl,
  output logic [CW-1:0] nibIdx,
  output logic [3:0]    ladOut,
  output logic          ladOe,
  output logic          wrStrobe
);

  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_NIBBLES - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DATA_NIBBLES - 1);

  busPhase_t phase, phaseNxt;
  logic [CW-1:0] cnt, cntNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phaseNxt;
      cnt   <= cntNxt;
    end
  end

  always_comb begin
    phaseNxt = phase;
    cntNxt   = cnt;
    dpCtl    = '0;
    if (!frameN) begin
      // A low frame strobe always wins: start or restart from the start field.
      cntNxt = '0;
      if (ladIn == NIB_START) begin
        phaseNxt    = ST_TYPE;
        dpCtl.clear = 1'b1;
      end else begin
        phaseNxt = ST_IDLE;
      end
    end else begin
      unique case (phase)
        ST_IDLE: phaseNxt = ST_IDLE;
        ST_TYPE: begin
          cntNxt   = '0;
          phaseNxt = isWriteType(ladIn) ? ST_ADDR : ST_IDLE;
        end
        ST_ADDR: begin
          dpCtl.shiftAddr = 1'b1;
          if (cnt == ADDR_LAST) begin
            cntNxt   = '0;
            phaseNxt = addrOk ? ST_DATA : ST_IDLE;
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
        ST_DATA: begin
          dpCtl.loadData = 1'b1;
          if (cnt == DATA_LAST) begin
            cntNxt   = '0;
            phaseNxt = ST_HTAR;
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
        ST_HTAR:  phaseNxt = ST_TTAR0;
        ST_TTAR0: phaseNxt = ST_SYNC;
        ST_SYNC:  phaseNxt = ST_TTAR1;
        ST_TTAR1: phaseNxt = ST_IDLE;
        default:  phaseNxt = ST_IDLE;
      endcase
    end
  end

  assign nibIdx   = cnt;
  assign ladOe    = (phase == ST_TTAR0) || (phase == ST_SYNC) || (phase == ST_TTAR1);
  assign ladOut   = (phase == ST_SYNC) ? NIB_SYNC : NIB_TURN;
  assign wrStrobe = (phase == ST_SYNC);

endmodule

// File: rtl/lpcw_dpath.sv
module lpcw_dpath
  import lpcw_pkg::*;
#(
  parameter int ADDR_NIBBLES = 8,
  parameter int DATA_NIBBLES = 2,
  parameter int CW           = 3,
  parameter int FILT_HI      = 31,
  parameter int FILT_LO      = 23,
  parameter int SEL_BIT      = 22
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [3:0]                ladIn,
  input  dpCtl_t                    dpCtl,
  input  logic [CW-1:0]             nibIdx,
  output logic                      addrOk,
  output logic [4*ADDR_NIBBLES-1:0] wrAddr,
  output logic [4*DATA_NIBBLES-1:0] wrData,
  output logic                      wrIsMem
);

  localparam int ADDR_W = 4 * ADDR_NIBBLES;

  logic [ADDR_W-1:0] addrSh;
  logic [ADDR_W-1:0] addrNext;

  // Most significant nibble arrives first, so shift left.
  assign addrNext = {addrSh[ADDR_W-5:0], ladIn};
  assign addrOk   = &addrNext[FILT_HI:FILT_LO];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrSh <= '0;
    end else if (dpCtl.clear) begin
      addrSh <= '0;
    end else if (dpCtl.shiftAddr) begin
      addrSh <= addrNext;
    end
  end

  // Least significant nibble arrives first; slot g takes nibble number g.
  for (genvar g = 0; g < DATA_NIBBLES; g++) begin : g_dataNib
    logic [3:0] nibReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nibReg <= '0;
      end else if (dpCtl.clear) begin
        nibReg <= '0;
      end else if (dpCtl.loadData && (nibIdx == CW'(g))) begin
        nibReg <= ladIn;
      end
    end
    assign wrData[4*g +: 4] = nibReg;
  end

  assign wrAddr  = addrSh;
  assign wrIsMem = addrSh[SEL_BIT];

endmodule

// File: rtl/lpc_write_target.sv
module lpc_write_target
  import lpcw_pkg::*;
#(
  parameter int ADDR_NIBBLES = 8,
  parameter int DATA_NIBBLES = 2,
  parameter int FILT_HI      = 31,
  parameter int FILT_LO      = 23,
  parameter int SEL_BIT      = 22
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      frameN,
  input  logic [3:0]                ladIn,
  output logic [3:0]                ladOut,
  output logic                      ladOe,
  output logic                      wrStrobe,
  output logic [4*ADDR_NIBBLES-1:0] wrAddr,
  output logic [4*DATA_NIBBLES-1:0] wrData,
  output logic                      wrIsMem
);

  localparam int MAXN = (ADDR_NIBBLES > DATA_NIBBLES) ? ADDR_NIBBLES : DATA_NIBBLES;
  localparam int CW   = (MAXN > 2) ? $clog2(MAXN) : 1;

  dpCtl_t        dpCtl;
  logic [CW-1:0] nibIdx;
  logic          addrOk;

  lpcw_ctrl #(
    .ADDR_NIBBLES(ADDR_NIBBLES),
    .DATA_NIBBLES(DATA_NIBBLES),
    .CW          (CW)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .frameN  (frameN),
    .ladIn   (ladIn),
    .addrOk  (addrOk),
    .dpCtl   (dpCtl),
    .nibIdx  (nibIdx),
    .ladOut  (ladOut),
    .ladOe   (ladOe),
    .wrStrobe(wrStrobe)
  );

  lpcw_dpath #(
    .ADDR_NIBBLES(ADDR_NIBBLES),
    .DATA_NIBBLES(DATA_NIBBLES),
    .CW          (CW),
    .FILT_HI     (FILT_HI),
    .FILT_LO     (FILT_LO),
    .SEL_BIT     (SEL_BIT)
  ) i_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .ladIn  (ladIn),
    .dpCtl  (dpCtl),
    .nibIdx (nibIdx),
    .addrOk (addrOk),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .wrIsMem(wrIsMem)
  );

endmodule

// File: rtl/lpcw_chk.sv
module lpcw_chk #(
  parameter int UW = 9
) (
  input logic          clk,
  input logic          rstN,
  input logic          frameN,
  input logic          ladOe,
  input logic [3:0]    ladOut,
  input logic          wrStrobe,
  input logic [UW-1:0] upperBits
);

  // R4
  filter_band_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (&upperBits));

  // R7
  sync_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (ladOe && ladOut == 4'b0000));

  // R7
  first_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ladOe) |-> (ladOut == 4'b1111));

  // R7
  post_sync_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && frameN) |=> (ladOe && ladOut == 4'b1111));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R9
  frame_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> (!ladOe && !wrStrobe));

endmodule

bind lpc_write_target lpcw_chk #(
  .UW(FILT_HI - FILT_LO + 1)
) i_lpcwChk (
  .clk      (clk),
  .rstN     (rstN),
  .frameN   (frameN),
  .ladOe    (ladOe),
  .ladOut   (ladOut),
  .wrStrobe (wrStrobe),
  .upperBits(wrAddr[FILT_HI:FILT_LO])
);

// File: tb/test_lpc_write_target.sv
module test_lpc_write_target;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1;
  logic        hostEn = 1'b0;
  logic [3:0]  hostLad = 4'hF;
  logic [3:0]  ladIn;
  logic [3:0]  ladOut;
  logic        ladOe;
  logic        wrStrobe;
  logic [31:0] wrAddr;
  logic [7:0]  wrData;
  logic        wrIsMem;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  // Bus model: target drive wins, then host, else pulled high.
  assign ladIn = ladOe ? ladOut : (hostEn ? hostLad : 4'hF);

  lpc_write_target i_lpc_write_target (
    .clk     (clk),
    .rstN    (rstN),
    .frameN  (frameN),
    .ladIn   (ladIn),
    .ladOut  (ladOut),
    .ladOe   (ladOe),
    .wrStrobe(wrStrobe),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .wrIsMem (wrIsMem)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // One host write cycle. Clock k is driven and checked at the negedge inside it.
  // firstK=2 continues a cycle whose start was already driven; stopAt returns before clock stopAt.
  task automatic runCycle(input logic [3:0] startNib, input logic [3:0] typ,
                          input logic [31:0] addr, input logic [7:0] data,
                          input bit expOk, input int firstK, input int stopAt,
                          input string tag);
    for (int k = firstK; k <= 17; k++) begin
      bit expOe;
      if (k == stopAt) return;
      @(negedge clk);
      expOe = expOk && (k >= 14) && (k <= 16);
      check({31'd0, ladOe}, {31'd0, expOe}, $sformatf("R7 %s oe clk%0d", tag, k));
      check({31'd0, wrStrobe}, {31'd0, expOk && k == 15}, $sformatf("R8 %s strobe clk%0d", tag, k));
      if (expOe)
        check({28'd0, ladOut}, (k == 15) ? 32'h0 : 32'hF, $sformatf("R7 %s lad clk%0d", tag, k));
      if (expOk && k == 15) begin
        check(wrAddr, addr, $sformatf("R3 %s addr", tag));
        check({24'd0, wrData}, {24'd0, data}, $sformatf("R6 %s data", tag));
        check({31'd0, wrIsMem}, {31'd0, addr[22]}, $sformatf("R5 %s space", tag));
      end
      frameN = (k == 1) ? 1'b0 : 1'b1;
      hostEn = (k <= 13);
      if (k == 1)       hostLad = startNib;
      else if (k == 2)  hostLad = typ;
      else if (k <= 10) hostLad = addr[31 - 4*(k-3) -: 4];
      else if (k <= 12) hostLad = data[4*(k-11) +: 4];
      else              hostLad = 4'hF;
    end
  endtask

  task automatic idleClocks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check({31'd0, ladOe}, 32'd0, $sformatf("%s idle oe", tag));
      check({31'd0, wrStrobe}, 32'd0, $sformatf("%s idle strobe", tag));
      frameN = 1'b1;
      hostEn = 1'b1;
      hostLad = 4'hF;
    end
  endtask

  // {expOk, type, address, data}
  localparam logic [44:0] VEC [8] = '{
    {1'b1, 4'h6, 32'hFFC0_1234, 8'hA5},  // memory write
    {1'b1, 4'h7, 32'hFF80_00F0, 8'h3C},  // register write, type bit 0 set
    {1'b0, 4'h2, 32'hFFC0_0000, 8'h11},  // type bits 3:2 wrong
    {1'b0, 4'h4, 32'hFFC0_0000, 8'h22},  // direction bit clear
    {1'b0, 4'h6, 32'hFF40_0000, 8'h33},  // bit 23 low
    {1'b0, 4'h6, 32'h7FC0_0000, 8'h44},  // bit 31 low
    {1'b1, 4'h6, 32'hFFFF_FFFF, 8'hFF},  // all ones
    {1'b1, 4'h7, 32'hFFBF_FFFE, 8'h01}   // register space, low bit patterns
  };

  initial begin
    // R10: reset state
    #3;
    check({31'd0, ladOe}, 32'd0, "R10 reset oe");
    check({31'd0, wrStrobe}, 32'd0, "R10 reset strobe");
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    idleClocks(2, "R10");

    // R2 R3 R4 R5 R6 R7 R8: vector table
    foreach (VEC[i]) begin
      runCycle(4'h0, VEC[i][43:40], VEC[i][39:8], VEC[i][7:0], VEC[i][44], 1, 0,
               $sformatf("R2/R4 vec%0d", i));
    end
    idleClocks(1, "R4");

    // R1: start nibble other than 0000 is ignored
    runCycle(4'h5, 4'h6, 32'hFFC0_5555, 8'h5A, 1'b0, 1, 0, "R1 badstart");
    idleClocks(1, "R1");

    // R9: frame low with 0000 during the address restarts the cycle
    runCycle(4'h0, 4'h6, 32'hFFC0_AAAA, 8'h77, 1'b1, 1, 6, "R9 pre");
    @(negedge clk);
    check({31'd0, ladOe}, 32'd0, "R9 restart oe");
    frameN = 1'b0; hostEn = 1'b1; hostLad = 4'h0;
    runCycle(4'h0, 4'h7, 32'hFFE0_0102, 8'h9C, 1'b1, 2, 0, "R9 restart");

    // R9: frame low with another nibble at the host turnaround drops the cycle
    runCycle(4'h0, 4'h6, 32'hFFC0_0BAD, 8'h66, 1'b1, 1, 13, "R9 pre2");
    @(negedge clk);
    check({31'd0, ladOe}, 32'd0, "R9 abort oe clk13");
    frameN = 1'b0; hostEn = 1'b1; hostLad = 4'hF;
    idleClocks(5, "R9 abort");

    // R10: reset in the sync clock floats the lines at once
    runCycle(4'h0, 4'h6, 32'hFFC0_0C0C, 8'h12, 1'b1, 1, 16, "R10 pre");
    rstN = 1'b0;
    #1;
    check({31'd0, ladOe}, 32'd0, "R10 async oe");
    check({31'd0, wrStrobe}, 32'd0, "R10 async strobe");
    @(negedge clk);
    rstN = 1'b1;
    idleClocks(2, "R10 after");

    // R1 R3: clean cycle after reset still works
    runCycle(4'h0, 4'h6, 32'hFFC1_2345, 8'hE7, 1'b1, 1, 0, "R1 post");
    idleClocks(1, "R7 tail");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule